// File: doc/BRIEF.md
# Serial Frame Transmitter with Idle and Break Generation

This block turns parallel words into asynchronous serial frames on one output line. A frame starts with a low start bit, carries the data word least significant bit first, and ends with a high stop bit. A mode input selects 8 or 9 data bits. When parity is enabled, the top data position carries an even or odd parity bit computed over the data bits below it. A caller can also ask for two special frames. An idle frame holds the line high for one full frame length. A break frame holds the line low for one full frame length and then drives one extra high bit.

An internal divider, used only by the transmitter, sets the bit rate. Each serial bit lasts the divisor value plus one clock cycles. A new request is accepted in any cycle where `load_i` is high and `busy_o` is low. `busy_o` stays high while the frame is on the line. `done_o` pulses for one clock when the last bit ends.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, `txd_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: When `kind_i` is 00 and `nine_i` is 0, the line carries 10 bits: a start bit 0, then `data_i[0]` through `data_i[7]` in that order, then a stop bit 1.
- R3: When `kind_i` is 00 and `nine_i` is 1, the line carries 11 bits: a start bit 0, then `data_i[0]` through `data_i[8]`, then a stop bit 1.
- R4: When `par_en_i` is 1, the top data position is replaced by a parity bit. That position is bit 7 in 8-bit mode and bit 8 in 9-bit mode. The parity bit is the XOR of the data bits below that position, inverted when `par_odd_i` is 1.
- R5: When `kind_i` is 01 (idle), the line stays 1 for N+2 bit times, where N is 8 or 9. `busy_o` stays high throughout and there is no start bit.
- R6: When `kind_i` is 10 (break), the line is 0 for N+2 bit times and then 1 for one extra bit time before the request completes.
- R7: Every bit lasts exactly `div_i`+1 clock cycles. The first bit appears in the cycle after the request is accepted, and `busy_o` stays high for every cycle of the frame.
- R8: In the cycle after the last bit ends, `done_o` is 1 for exactly one clock, `busy_o` is 0 and `txd_o` is 1.
- R9: A `load_i` pulse while `busy_o` is high is ignored. The frame in progress continues unchanged, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | 8 | Bit-period divisor; each bit lasts div_i+1 clocks |
| nine_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en_i | input | 1 | Parity replaces the top data bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| kind_i | input | 2 | 00 data, 01 idle frame, 10 break frame |
| data_i | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| load_i | input | 1 | Request; accepted when busy_o is low |
| busy_o | output | 1 | A frame is on the line |
| done_o | output | 1 | One-clock pulse when a frame completes |
| txd_o | output | 1 | Serial output line |

## Verification
With the divisor at zero, every possible 8-bit word is sent with and without parity in both parity senses. Every 9-bit word is sent both raw and with parity. These sweeps catch a bit-order or position error on any data line, and they show whether the parity bit lands on bit 7 or bit 8 and whether its sense is right. Larger divisors use a few corner words plus idle and break frames. Those frames separate a wrong bit length or frame length from a missing extra high bit after a break. One frame gets a stray mid-frame request, which shows that a request taken while busy would corrupt the line or start a frame that was never accepted.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    K_DATA  = 2'b00,
    K_IDLE  = 2'b01,
    K_BREAK = 2'b10,
    K_RSVD  = 2'b11
  } stx_kind_e;

  // Number of data bits in the active word length.
  function automatic int stx_nbits(logic nine);
    return nine ? DATA_W : DATA_W - 1;
  endfunction

  // Parity over the bits below the top data position.
  function automatic logic stx_parity(logic [DATA_W-1:0] d, logic nine, logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DATA_W - 1; i++)
      if (i < stx_nbits(nine) - 1) p = p ^ d[i];
    return p;
  endfunction

  // Line bits of the frame in send order (index 0 goes first).
  function automatic logic [FRAME_W-1:0] stx_frame(stx_kind_e k, logic nine,
                                                   logic pen, logic podd,
                                                   logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] f;
    int n;
    n = stx_nbits(nine);
    if (k == K_IDLE) begin
      f = '1;
    end else if (k == K_BREAK) begin
      f = '0;
      for (int i = 0; i < FRAME_W; i++)
        if (i == n + 2) f[i] = 1'b1;
    end else begin
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (i < n) f[i+1] = (pen && i == n - 1) ? stx_parity(d, nine, podd) : d[i];
    end
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] stx_len(stx_kind_e k, logic nine);
    return LEN_W'(stx_nbits(nine) + ((k == K_BREAK) ? 3 : 2));
  endfunction
endpackage

// File: rtl/stx_baud.sv
module stx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stx_frame_build.sv
module stx_frame_build
  import stx_pkg::*;
(
  input  stx_kind_e           kind,
  input  logic                nine,
  input  logic                pen,
  input  logic                podd,
  input  logic [DATA_W-1:0]   data,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEN_W-1:0]    len
);
  always_comb begin
    frame = stx_frame(kind, nine, pen, podd, data);
    len   = stx_len(kind, nine);
  end
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import stx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              nine_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              txd_o
);
  logic [FRAME_W-1:0] frame_w, frame_q;
  logic [LEN_W-1:0]   len_w, len_q, idx_q;
  stx_kind_e          kind_q;
  logic               busy_q, done_q, txd_q;
  logic               tick_w, accept_w, last_w;

  assign accept_w = load_i && !busy_q;
  assign last_w   = (idx_q == len_q - 1'b1);

  stx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .div(div_i), .tick(tick_w)
  );

  stx_frame_build u_build (
    .kind(stx_kind_e'(kind_i)), .nine(nine_i), .pen(par_en_i), .podd(par_odd_i),
    .data(data_i), .frame(frame_w), .len(len_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      kind_q  <= K_DATA;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        frame_q <= frame_w;
        len_q   <= len_w;
        idx_q   <= '0;
        kind_q  <= stx_kind_e'(kind_i);
        busy_q  <= 1'b1;
        txd_q   <= frame_w[0];
      end else if (tick_w) begin
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          txd_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          txd_q <= frame_q[idx_q + 1'b1];
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign txd_o  = txd_q;
endmodule

// File: rtl/stx_checker.sv
module stx_checker
  import stx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             txd_o,
  input logic             tick_w,
  input logic             accept_w,
  input stx_kind_e        kind_q,
  input logic [LEN_W-1:0] idx_q,
  input logic [LEN_W-1:0] len_q
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && txd_o));

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> txd_o);

  assert_line_paced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_o) |-> $past(tick_w || accept_w));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && (kind_q == K_DATA || kind_q == K_RSVD)) |-> !txd_o);

  assert_idle_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && kind_q == K_IDLE) |-> txd_o);

  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q < len_q));
endmodule

bind serial_tx_engine stx_checker u_stx_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .txd_o(txd_o),
  .tick_w(tick_w), .accept_w(accept_w), .kind_q(kind_q), .idx_q(idx_q), .len_q(len_q)
);

// File: tb/sim_serial_tx_engine.sv
`timescale 1ns/1ps
module sim_serial_tx_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = '0;
  logic       nine_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0;
  logic [1:0] kind_i = 2'b00;
  logic [8:0] data_i = '0;
  logic       load_i = 1'b0;
  logic       busy_o, done_o, txd_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  serial_tx_engine u0 (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .nine_i(nine_i), .par_en_i(par_en_i),
    .par_odd_i(par_odd_i), .kind_i(kind_i), .data_i(data_i), .load_i(load_i),
    .busy_o(busy_o), .done_o(done_o), .txd_o(txd_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Sends one request and checks the line on every cycle of it.
  task automatic send(input logic [1:0] k, input logic [8:0] d, input bit poke);
    logic exp_bits [0:11];
    string tag [0:11];
    int n, len, ones;
    n = nine_i ? 9 : 8;
    for (int i = 0; i < 12; i++) begin exp_bits[i] = 1'b1; tag[i] = "R5"; end
    if (k == 2'b01) begin
      len = n + 2;
    end else if (k == 2'b10) begin
      len = n + 3;
      for (int i = 0; i < 12; i++) begin exp_bits[i] = (i == n + 2); tag[i] = "R6"; end
    end else begin
      len = n + 2;
      ones = 0;
      for (int i = 0; i < n - 1; i++) ones += d[i];
      exp_bits[0] = 1'b0;
      tag[0] = "R2";
      for (int i = 0; i < n; i++) begin
        exp_bits[i+1] = d[i];
        tag[i+1] = nine_i ? "R3" : "R2";
      end
      if (par_en_i) begin
        exp_bits[n] = ((ones % 2) == 1) ^ par_odd_i;
        tag[n] = "R4";
      end
      tag[n+1] = nine_i ? "R3" : "R2";
    end
    @(negedge clk);
    kind_i = k; data_i = d; load_i = 1'b1;
    @(posedge clk);
    for (int b = 0; b < len; b++) begin
      for (int c = 0; c <= int'(div_i); c++) begin
        @(negedge clk);
        if (b == 0 && c == 0) load_i = 1'b0;
        if (poke && b == 2 && c == 1) load_i = 1'b0;
        chk(txd_o == exp_bits[b], tag[b], txd_o, exp_bits[b]);
        chk(busy_o === 1'b1, "R7", busy_o, 1);
        if (poke && b == 2 && c == 0) begin
          load_i = 1'b1; kind_i = 2'b10; data_i = ~d;   // R9 stray request
        end
        @(posedge clk);
      end
    end
    @(negedge clk);
    load_i = 1'b0;
    chk(done_o === 1'b1, "R8", done_o, 1);
    chk(busy_o === 1'b0, "R8", busy_o, 0);
    chk(txd_o === 1'b1, "R8", txd_o, 1);
    @(negedge clk);
    chk(done_o === 1'b0, "R8", done_o, 0);
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        chk(busy_o === 1'b0 && txd_o === 1'b1, "R9", {busy_o, txd_o}, 1);
        @(negedge clk);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(txd_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1",
        {txd_o, busy_o, done_o}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1",
        {txd_o, busy_o, done_o}, 4);

    // Exhaustive 8-bit words, all parity settings (R2, R4).
    div_i = 8'd0; nine_i = 1'b0;
    for (int p = 0; p < 3; p++) begin
      par_en_i = (p != 0); par_odd_i = (p == 2);
      for (int w = 0; w < 256; w++) send(2'b00, 9'(w), 1'b0);
    end
    // Exhaustive 9-bit words, raw and with both parity senses (R3, R4).
    nine_i = 1'b1;
    for (int p = 0; p < 3; p++) begin
      par_en_i = (p != 0); par_odd_i = (p == 2);
      for (int w = 0; w < 512; w++) send(2'b00, 9'(w), 1'b0);
    end
    // Slower bit rates with corner words, idle and break (R5, R6, R7).
    for (int dv = 1; dv < 6; dv += 2) begin
      div_i = 8'(dv);
      for (int nb = 0; nb < 2; nb++) begin
        nine_i = nb[0]; par_en_i = 1'b1; par_odd_i = nb[0];
        send(2'b00, 9'h000, 1'b0);
        send(2'b00, 9'h1A5, 1'b0);
        par_en_i = 1'b0;
        send(2'b00, 9'h1FF, 1'b0);
        send(2'b00, 9'h15A, 1'b0);
        send(2'b01, 9'h000, 1'b0);
        send(2'b10, 9'h1FF, 1'b0);
        send(2'b10, 9'h000, 1'b0);
      end
    end
    // Requests while busy are ignored (R9).
    div_i = 8'd3; nine_i = 1'b0;
    send(2'b00, 9'h0C3, 1'b1);
    send(2'b01, 9'h000, 1'b1);

    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule